// File: doc/BRIEF.md
# Rotate-Mask Jump Table Displacement Unit

This block turns a bit field held in an 8-bit register into a branch offset for a jump table. A copy of the register is rotated toward bit 0 by a selectable count. Bits that fall off the bottom come back in at the top. The upper bits of the result, as many as a second count selects, are then forced to zero. Bit 0 is always forced to zero as well. The 8-bit value left over is read as a two's-complement displacement. It is sign-extended and added to a program counter that already points at the instruction after the jump.

Bit 0 is always zero, so consecutive field values land two words apart. Each table slot can therefore hold either a one-word or a two-word jump. The source register is never written back; the block only reads it. Table contents and instruction fetch belong to the surrounding processor. The displacement and the target address are both registered, so results appear one clock after the operands are presented.

Top module: `rmj_disp_top`

## Requirements
- R1: The register copy is rotated right by `rot_amt` (0 to 7) positions, with bit i of the result taken from source bit (i + `rot_amt`) mod 8; a count of 0 leaves the copy unrotated.
- R2: After rotation, the `mask_cnt` most significant bits (0 to 7) of the 8-bit value are forced to zero.
- R3: Bit 0 of `disp_out` is always zero, so the displacement is even and lies within -128 to +126.
- R4: `target_pc` equals `pc_next` plus `disp_out` sign-extended from bit 7 to 16 bits, wrapping modulo 2^16.
- R5: `disp_out` and `target_pc` are registered: they reflect the operands sampled at the previous rising clock edge and hold steady between edges.
- R6: A synchronous active-high `rst` clears `disp_out` and `target_pc` to zero at the next rising edge.
- R7: With a rotate count of 1 and a mask count of 4, a source laid out as xxxFFFyy (three-bit field F in bits 4..2) yields 0000FFF0; field value 001 gives a displacement of +2.
- R8: A mask count of 7 clears every bit, so the displacement is 0 and `target_pc` equals `pc_next`.
- R9: When bit 7 survives rotation and masking, the displacement is negative; for example, a rotated value of 0x80 subtracts 128 from the program counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_word | input | 8 | Copy of the source register holding the field |
| rot_amt | input | 3 | Right-rotate count |
| mask_cnt | input | 3 | Number of upper bits to clear after rotation |
| pc_next | input | 16 | Address of the instruction after the jump |
| disp_out | output | 8 | Registered signed displacement |
| target_pc | output | 16 | Registered branch target |

## Verification
The bench sweeps every source value under every rotate and mask count against its own bit-level reference. This catches a rotator that shifts instead of wrapping, since zeros would replace the wrapped bits. It also catches an off-by-one mask boundary, which would clear one bit too many or too few. Directed vectors go after bit 7 surviving at mask count 0, where a zero-extending adder would jump forward instead of back by 128. They also cover a program counter near 0xFFFF or 0x0000 where the sum must wrap, and a mask count of 7 that must leave the target equal to the incoming PC. Separate checks confirm that the outputs do not move before the clock edge and that a mid-run reset clears them.

// File: rtl/rmj_pkg.sv
package rmj_pkg;

    localparam int DATA_W  = 8;
    localparam int PC_W    = 16;
    localparam int CNT_W   = $clog2(DATA_W);
    localparam int EXT_W   = PC_W - DATA_W;

    typedef logic [DATA_W-1:0] field_t;
    typedef logic [PC_W-1:0]   pc_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef struct packed {
        field_t disp;
        pc_t    target;
    } jump_result_t;

    function automatic pc_t widen_signed(field_t d);
        return {{EXT_W{d[DATA_W-1]}}, d};
    endfunction

endpackage

// File: rtl/rmj_rotator.sv
module rmj_rotator #(
    parameter int W  = rmj_pkg::DATA_W,
    localparam int SW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] amt,
    output logic [W-1:0]  dout
);

    logic [W-1:0] stage [0:SW];

    assign stage[0] = din;

    for (genvar k = 0; k < SW; k++) begin : g_stage
        localparam int STEP = 1 << k;
        assign stage[k+1] = amt[k] ? {stage[k][STEP-1:0], stage[k][W-1:STEP]}
                                   : stage[k];
    end

    assign dout = stage[SW];

endmodule

// File: rtl/rmj_masker.sv
module rmj_masker #(
    parameter int W  = rmj_pkg::DATA_W,
    localparam int SW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] cnt,
    output logic [W-1:0]  dout
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == 0) begin : g_lsb
            assign dout[i] = 1'b0;
        end else begin : g_upper
            assign dout[i] = din[i] & (int'(cnt) < (W - i));
        end
    end

endmodule

// File: rtl/rmj_target_adder.sv
module rmj_target_adder #(
    parameter int W  = rmj_pkg::DATA_W,
    parameter int PW = rmj_pkg::PC_W
) (
    input  logic [PW-1:0] pc_in,
    input  logic [W-1:0]  disp,
    output logic [PW-1:0] target
);

    assign target = pc_in + {{(PW-W){disp[W-1]}}, disp};

endmodule

// File: rtl/rmj_disp_top.sv
module rmj_disp_top
    import rmj_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  src_word,
    input  logic [2:0]  rot_amt,
    input  logic [2:0]  mask_cnt,
    input  logic [15:0] pc_next,
    output logic [7:0]  disp_out,
    output logic [15:0] target_pc
);

    field_t       rotated;
    field_t       masked;
    pc_t          sum;
    jump_result_t res_d;
    jump_result_t res_q;

    rmj_rotator #(.W(DATA_W)) u_rot (
        .din  (src_word),
        .amt  (rot_amt),
        .dout (rotated)
    );

    rmj_masker #(.W(DATA_W)) u_mask (
        .din  (rotated),
        .cnt  (mask_cnt),
        .dout (masked)
    );

    rmj_target_adder #(.W(DATA_W), .PW(PC_W)) u_add (
        .pc_in  (pc_next),
        .disp   (masked),
        .target (sum)
    );

    always_comb begin
        res_d.disp   = masked;
        res_d.target = sum;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign disp_out  = res_q.disp;
    assign target_pc = res_q.target;

    AST_DISP_EVEN: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (disp_out[0] == 1'b0)); // R3

    AST_UPPER_CLEARED: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((disp_out >> (DATA_W - int'($past(mask_cnt)))) == '0)); // R2

    AST_NO_ROTATE: assert property (@(posedge clk) disable iff (rst)
        (!rst && rot_amt == '0 && mask_cnt == '0) |=>
            (disp_out == ($past(src_word) & 8'hFE))); // R1

    AST_TARGET_SUM: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (target_pc == $past(pc_next) + widen_signed(disp_out))); // R4

    AST_FULL_MASK: assert property (@(posedge clk) disable iff (rst)
        (!rst && mask_cnt == 3'd7) |=>
            (disp_out == '0 && target_pc == $past(pc_next))); // R8

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (disp_out == '0 && target_pc == '0)); // R6

endmodule

// File: tb/rmj_disp_top_tb.sv
module rmj_disp_top_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  src_word;
    logic [2:0]  rot_amt;
    logic [2:0]  mask_cnt;
    logic [15:0] pc_next;
    logic [7:0]  disp_out;
    logic [15:0] target_pc;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    rmj_disp_top u_dut (
        .clk       (clk),
        .rst       (rst),
        .src_word  (src_word),
        .rot_amt   (rot_amt),
        .mask_cnt  (mask_cnt),
        .pc_next   (pc_next),
        .disp_out  (disp_out),
        .target_pc (target_pc)
    );

    // {src, rot, mask, pc, expected disp, expected target}
    localparam logic [55:0] VEC [10] = '{
        {8'h5B, 4'd0, 4'd0, 16'h1000, 8'h5A, 16'h105A}, // R1 no rotate
        {8'hE7, 4'd1, 4'd4, 16'h2000, 8'h02, 16'h2002}, // R7 field 001
        {8'h80, 4'd0, 4'd0, 16'h0100, 8'h80, 16'h0080}, // R9 -128
        {8'h01, 4'd1, 4'd0, 16'h0000, 8'h80, 16'hFF80}, // R4 wrap down
        {8'hFF, 4'd3, 4'd7, 16'h1234, 8'h00, 16'h1234}, // R8 full mask
        {8'hFF, 4'd0, 4'd1, 16'h8000, 8'h7E, 16'h807E}, // R3 max +126
        {8'hFF, 4'd0, 4'd0, 16'h0010, 8'hFE, 16'h000E}, // R3 -2
        {8'h12, 4'd4, 4'd0, 16'hFFF0, 8'h20, 16'h0010}, // R4 wrap up
        {8'h03, 4'd7, 4'd2, 16'h4000, 8'h06, 16'h4006}, // R1 rotate 7
        {8'hC0, 4'd2, 4'd3, 16'h0500, 8'h10, 16'h0510}  // R2 mask 3
    };

    function automatic logic [7:0] ref_disp(logic [7:0] s, int b, int m);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = s[(i + b) % 8];
        for (int i = 0; i < 8; i++) if (i == 0 || i >= 8 - m) r[i] = 1'b0;
        return r;
    endfunction

    function automatic logic [15:0] ref_target(logic [15:0] pc, logic [7:0] d);
        int sd;
        sd = d[7] ? int'(d) - 256 : int'(d);
        return 16'(int'(pc) + sd);
    endfunction

    task automatic check(string req, logic [7:0] gd, logic [7:0] ed,
                         logic [15:0] gt, logic [15:0] et);
        n_vec++;
        if (gd !== ed || gt !== et) begin
            n_fail++;
            $display("FAIL %s: disp=%h target=%h expected disp=%h target=%h",
                     req, gd, gt, ed, et);
        end
    endtask

    task automatic drive(logic [7:0] s, logic [2:0] b, logic [2:0] m, logic [15:0] pc);
        @(negedge clk);
        src_word = s; rot_amt = b; mask_cnt = m; pc_next = pc;
    endtask

    initial begin
        rst = 1'b1; src_word = 8'hA5; rot_amt = 3'd2; mask_cnt = 3'd0; pc_next = 16'h1111;
        repeat (3) @(posedge clk);
        #1 check("R6 reset", disp_out, 8'h00, target_pc, 16'h0000);
        @(negedge clk) rst = 1'b0;

        for (int v = 0; v < 10; v++) begin
            drive(VEC[v][55:48], VEC[v][46:44], VEC[v][42:40], VEC[v][39:24]);
            @(posedge clk);
            #1 check("R1-table", disp_out, VEC[v][23:16], target_pc, VEC[v][15:0]);
        end

        // R5: new operands must not show before the edge
        drive(8'hE7, 3'd1, 3'd4, 16'h2000);
        @(posedge clk);
        #1 check("R5 load", disp_out, 8'h02, target_pc, 16'h2002);
        drive(8'h80, 3'd0, 3'd0, 16'h0100);
        #1 check("R5 hold", disp_out, 8'h02, target_pc, 16'h2002);
        @(posedge clk);
        #1 check("R5 update", disp_out, 8'h80, target_pc, 16'h0080);

        // R6: reset in mid-run
        @(negedge clk) rst = 1'b1;
        @(posedge clk);
        #1 check("R6 midrun", disp_out, 8'h00, target_pc, 16'h0000);
        @(negedge clk) rst = 1'b0;

        // R1 R2 R3 R4: exhaustive sweep
        for (int s = 0; s < 256; s++) begin
            for (int b = 0; b < 8; b++) begin
                for (int m = 0; m < 8; m++) begin
                    logic [15:0] pc;
                    logic [7:0]  ed;
                    pc = 16'((s * 257 + b * 4099 + m * 613) & 16'hFFFF);
                    ed = ref_disp(8'(s), b, m);
                    drive(8'(s), 3'(b), 3'(m), pc);
                    @(posedge clk);
                    #1 check("R2 sweep", disp_out, ed, target_pc, ref_target(pc, ed));
                end
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run hung, actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule